// File: doc/BRIEF.md
# Accumulator/Link Micro-Operation Unit

This block carries out the register-only operate micro-operations of a 12-bit accumulator machine that also has a one-bit link. An 8-bit micro-operation field arrives with the current accumulator and link. The block returns the updated accumulator and link. It also returns four usage flags that tell the surrounding pipeline whether the word reads or writes each register. The flags let the pipeline handle hazards and skip writes that are not needed.

Several micro-operations can be set in one word, and they always take effect in one fixed sequence. First come the clears. Then come the complements. Then an increment of the 13-bit link:accumulator pair. Last comes either a rotate of that pair or a half-swap of the accumulator. The logic is combinational, and its result is captured in one output register stage. A valid bit travels with each result. When no new word arrives, the registered results hold.

Top module: `opr1_unit`

## Requirements
- R1: Field bit 7 set forces the accumulator to zero, and field bit 6 set forces the link to zero, before any other step.
- R2: Field bit 5 inverts all 12 accumulator bits, and field bit 4 inverts the link. Both inversions act on the values left after the clears.
- R3: Field bit 0 adds one to the 13-bit value {link, accumulator}, modulo 2^13. A carry out of accumulator bit 11 therefore inverts the link, and the accumulator stays 12 bits wide.
- R4: When several steps are set, they run in this order: clears, then inversions, then the increment, then the rotate or swap step.
- R5: Field bit 3 rotates the 13-bit pair {link, accumulator} right by one: link goes to accumulator bit 11, and accumulator bit 0 goes to link. Field bit 2 rotates it left by one. When both bits 3 and 2 are set, only the right rotate takes place.
- R6: Field bit 1 set together with bit 3 or bit 2 makes that rotate move two positions instead of one.
- R7: Field bit 1 with neither rotate bit set exchanges accumulator bits 11..6 with bits 5..0 and leaves the link unchanged.
- R8: An all-zero field returns the accumulator and link unchanged, and all four usage flags are zero.
- R9: The accumulator-read flag is set when any of field bits 5, 3, 2, 1 or 0 is set. The link-read flag is set when any of bits 4, 3, 2 or 0 is set.
- R10: The accumulator-write flag is set when any of bits 7, 5, 3, 2, 1 or 0 is set. The link-write flag is set when any of bits 6, 4, 3, 2 or 0 is set. A register whose write flag is clear comes back unchanged.
- R11: A word accepted with in_valid high at a rising clock edge has its results and flags on the outputs just after that edge, with out_valid high. When in_valid is low at an edge, out_valid goes low at that edge and the data and flag outputs keep their values.
- R12: While rst_n is low, out_valid and all data and flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new micro-operation word is present |
| in_uop | input | 8 | Micro-operation field (bit meanings in R1 to R7) |
| in_acc | input | 12 | Current accumulator |
| in_link | input | 1 | Current link |
| out_valid | output | 1 | Registered result is from a word accepted at the last edge |
| out_acc | output | 12 | New accumulator |
| out_link | output | 1 | New link |
| out_rd_acc | output | 1 | Word reads the accumulator |
| out_rd_link | output | 1 | Word reads the link |
| out_wr_acc | output | 1 | Word writes the accumulator |
| out_wr_link | output | 1 | Word writes the link |

## Verification
The bench goes after the ordering cases, and each has a distinct wrong result.
- Clear plus invert gives all ones. A design that inverts before clearing returns zero.
- Clear plus increment gives one. A design that increments before clearing also returns zero.
- An increment at all-ones must wrap the accumulator and flip the link. A design that keeps the carry out of the link leaves the link as it was.
- A rotate must carry the link through the ends. A 12-bit rotate loses the link bit.
- A rotate with bit 1 set must move two places. A design that treats bit 1 as a swap there scrambles the halves.

All 256 field values are also run against several accumulator patterns, so that every usage-flag combination is compared. Gaps in in_valid show whether the outputs hold their values.

// File: rtl/opr1_pkg.sv
package opr1_pkg;
  localparam int UOP_W  = 8;
  localparam int B_INC  = 0;
  localparam int B_DBL  = 1;
  localparam int B_ROTL = 2;
  localparam int B_ROTR = 3;
  localparam int B_CMPL = 4;
  localparam int B_CMPA = 5;
  localparam int B_CLRL = 6;
  localparam int B_CLRA = 7;

  typedef struct packed {
    logic clr_acc;
    logic clr_link;
    logic cmp_acc;
    logic cmp_link;
    logic rot_r;
    logic rot_l;
    logic dbl;
    logic inc;
  } opr1_ctl_t;

  typedef struct packed {
    logic rd_acc;
    logic rd_link;
    logic wr_acc;
    logic wr_link;
  } opr1_use_t;
endpackage

// File: rtl/opr1_decode.sv
module opr1_decode
  import opr1_pkg::*;
(
  input  logic [UOP_W-1:0] uop,
  output opr1_ctl_t        ctl,
  output opr1_use_t        usage
);
  logic any_rot;

  always_comb begin
    ctl.clr_acc  = uop[B_CLRA];
    ctl.clr_link = uop[B_CLRL];
    ctl.cmp_acc  = uop[B_CMPA];
    ctl.cmp_link = uop[B_CMPL];
    // right rotate has priority over left when both are coded
    ctl.rot_r    = uop[B_ROTR];
    ctl.rot_l    = uop[B_ROTL] & ~uop[B_ROTR];
    ctl.dbl      = uop[B_DBL];
    ctl.inc      = uop[B_INC];
  end

  assign any_rot = uop[B_ROTR] | uop[B_ROTL];

  always_comb begin
    usage.rd_acc  = uop[B_CMPA] | any_rot | uop[B_DBL] | uop[B_INC];
    usage.rd_link = uop[B_CMPL] | any_rot | uop[B_INC];
    usage.wr_acc  = uop[B_CLRA] | uop[B_CMPA] | any_rot | uop[B_DBL] | uop[B_INC];
    usage.wr_link = uop[B_CLRL] | uop[B_CMPL] | any_rot | uop[B_INC];
  end
endmodule

// File: rtl/opr1_datapath.sv
module opr1_datapath
  import opr1_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  opr1_ctl_t        ctl,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             link_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             link_out,
  output logic [ACC_W:0]   inc_pair
);
  localparam int PAIR_W = ACC_W + 1;
  localparam int HALF   = ACC_W / 2;

  function automatic logic [PAIR_W-1:0] rot_right(input logic [PAIR_W-1:0] p, input int n);
    return (p >> n) | (p << (PAIR_W - n));
  endfunction

  function automatic logic [PAIR_W-1:0] rot_left(input logic [PAIR_W-1:0] p, input int n);
    return (p << n) | (p >> (PAIR_W - n));
  endfunction

  function automatic logic [ACC_W-1:0] swap_halves(input logic [ACC_W-1:0] a);
    return {a[HALF-1:0], a[ACC_W-1:HALF]};
  endfunction

  logic [ACC_W-1:0]  acc_clr, acc_cmp;
  logic              link_clr, link_cmp;
  logic [PAIR_W-1:0] pair_fin;
  int                shamt;

  // step 1 and 2: clears, then inversions
  always_comb begin
    acc_clr  = ctl.clr_acc  ? '0 : acc_in;
    link_clr = ctl.clr_link ? 1'b0 : link_in;
    acc_cmp  = ctl.cmp_acc  ? ~acc_clr : acc_clr;
    link_cmp = ctl.cmp_link ? ~link_clr : link_clr;
  end

  // step 3: increment across the whole pair so the carry lands in the link
  assign inc_pair = ctl.inc ? ({link_cmp, acc_cmp} + PAIR_W'(1)) : {link_cmp, acc_cmp};

  // step 4: rotate by one or two, or swap accumulator halves
  assign shamt = ctl.dbl ? 2 : 1;

  always_comb begin
    if (ctl.rot_r)       pair_fin = rot_right(inc_pair, shamt);
    else if (ctl.rot_l)  pair_fin = rot_left(inc_pair, shamt);
    else if (ctl.dbl)    pair_fin = {inc_pair[PAIR_W-1], swap_halves(inc_pair[ACC_W-1:0])};
    else                 pair_fin = inc_pair;
  end

  assign acc_out  = pair_fin[ACC_W-1:0];
  assign link_out = pair_fin[PAIR_W-1];
endmodule

// File: rtl/opr1_outreg.sv
module opr1_outreg
  import opr1_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] res_acc,
  input  logic             res_link,
  input  opr1_use_t        res_use,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_acc,
  output logic             out_link,
  output opr1_use_t        out_use
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
      out_link  <= 1'b0;
      out_use   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_acc  <= res_acc;
        out_link <= res_link;
        out_use  <= res_use;
      end
    end
  end

  // R11
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_acc) && $stable(out_link) && $stable(out_use)));
endmodule

// File: rtl/opr1_unit.sv
module opr1_unit
  import opr1_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_uop,
  input  logic [ACC_W-1:0] in_acc,
  input  logic             in_link,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_acc,
  output logic             out_link,
  output logic             out_rd_acc,
  output logic             out_rd_link,
  output logic             out_wr_acc,
  output logic             out_wr_link
);
  localparam int PAIR_W = ACC_W + 1;

  opr1_ctl_t        ctl;
  opr1_use_t        usage, usage_q;
  logic [ACC_W-1:0] res_acc;
  logic             res_link;
  logic [ACC_W:0]   inc_pair;

  opr1_decode u_dec (
    .uop   (in_uop),
    .ctl   (ctl),
    .usage (usage)
  );

  opr1_datapath #(.ACC_W(ACC_W)) u_dp (
    .ctl      (ctl),
    .acc_in   (in_acc),
    .link_in  (in_link),
    .acc_out  (res_acc),
    .link_out (res_link),
    .inc_pair (inc_pair)
  );

  opr1_outreg #(.ACC_W(ACC_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .res_acc   (res_acc),
    .res_link  (res_link),
    .res_use   (usage),
    .out_valid (out_valid),
    .out_acc   (out_acc),
    .out_link  (out_link),
    .out_use   (usage_q)
  );

  assign out_rd_acc  = usage_q.rd_acc;
  assign out_rd_link = usage_q.rd_link;
  assign out_wr_acc  = usage_q.wr_acc;
  assign out_wr_link = usage_q.wr_link;

  // R10
  keep_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !usage.wr_acc) |-> (res_acc == in_acc));

  // R10
  keep_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !usage.wr_link) |-> (res_link == in_link));

  // R8
  nop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_uop == 8'h00) |-> (usage == '0 && res_acc == in_acc && res_link == in_link));

  // R3
  inc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_uop == 8'h01) |-> ({res_link, res_acc} == ({in_link, in_acc} + PAIR_W'(1))));

  // R3
  inc_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_uop == 8'h01) |-> (inc_pair == {res_link, res_acc}));
endmodule

// File: tb/opr1_unit_tb_top.sv
module opr1_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_uop = 8'h00;
  logic [11:0] in_acc = 12'h000;
  logic        in_link = 1'b0;
  logic        out_valid;
  logic [11:0] out_acc;
  logic        out_link;
  logic        out_rd_acc, out_rd_link, out_wr_acc, out_wr_link;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected registered state
  int e_valid = 0, e_acc = 0, e_link = 0;
  int e_ra = 0, e_rl = 0, e_wa = 0, e_wl = 0;
  string e_tag = "R12";

  always #10 clk = ~clk;

  opr1_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uop(in_uop),
    .in_acc(in_acc), .in_link(in_link), .out_valid(out_valid),
    .out_acc(out_acc), .out_link(out_link), .out_rd_acc(out_rd_acc),
    .out_rd_link(out_rd_link), .out_wr_acc(out_wr_acc), .out_wr_link(out_wr_link)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  // behavioural reference: result pair as link*4096 + acc
  function automatic int ref_pair(input int u, input int a, input int l);
    int v, n;
    if (u & 8'o200) a = 0;                 // R1
    if (u & 8'o100) l = 0;                 // R1
    if (u & 8'o040) a = a ^ 4095;          // R2
    if (u & 8'o020) l = l ^ 1;             // R2
    v = l * 4096 + a;
    if (u & 8'o001) v = (v + 1) % 8192;    // R3
    n = (u & 8'o002) ? 2 : 1;              // R6
    if (u & 8'o010)      v = ((v >> n) | (v << (13 - n))) & 8191;   // R5
    else if (u & 8'o004) v = ((v << n) | (v >> (13 - n))) & 8191;   // R5
    else if (u & 8'o002) v = (v & 4096) | ((v & 63) << 6) | ((v >> 6) & 63); // R7
    return v;
  endfunction

  function automatic string tag_of(input int u);
    if (u == 0) return "R8";
    if ((u & 8'o014) != 0 && (u & 8'o002) != 0) return "R6";
    if ((u & 8'o014) != 0) return "R5";
    if ((u & 8'o002) != 0) return "R7";
    if ((u & 8'o001) != 0 && (u & 8'o360) != 0) return "R4";
    if ((u & 8'o001) != 0) return "R3";
    if ((u & 8'o060) != 0) return "R2";
    return "R1";
  endfunction

  task automatic compare_outputs();
    check("R11", "out_valid", int'(out_valid), e_valid);
    check(e_tag, "out_acc", int'(out_acc), e_acc);
    check(e_tag, "out_link", int'(out_link), e_link);
    check("R9", "out_rd_acc", int'(out_rd_acc), e_ra);
    check("R9", "out_rd_link", int'(out_rd_link), e_rl);
    check("R10", "out_wr_acc", int'(out_wr_acc), e_wa);
    check("R10", "out_wr_link", int'(out_wr_link), e_wl);
  endtask

  // one cycle: check what the last edge produced, then present a new word
  task automatic step(input bit v, input int u, input int a, input int l);
    int p;
    @(negedge clk);
    compare_outputs();
    in_valid = v;
    in_uop   = 8'(u);
    in_acc   = 12'(a);
    in_link  = 1'(l);
    e_valid  = v;
    if (v) begin
      p      = ref_pair(u, a, l);
      e_acc  = p % 4096;
      e_link = p / 4096;
      e_ra   = ((u & 8'o057) != 0) ? 1 : 0;  // R9
      e_rl   = ((u & 8'o035) != 0) ? 1 : 0;  // R9
      e_wa   = ((u & 8'o257) != 0) ? 1 : 0;  // R10
      e_wl   = ((u & 8'o135) != 0) ? 1 : 0;  // R10
      e_tag  = tag_of(u);
    end else begin
      e_tag  = "R11";                          // hold check
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int accs [6] = '{0, 4095, 8'o0, 12'o5252, 12'o1234, 12'o7700};
    // R12: outputs during reset
    repeat (2) @(negedge clk);
    compare_outputs();
    rst_n = 1'b1;

    // directed corner cases
    step(1, 8'o000, 12'o5252, 1);   // R8 no-op
    step(1, 8'o200, 12'o1234, 1);   // R1 clear acc
    step(1, 8'o100, 12'o1234, 1);   // R1 clear link
    step(1, 8'o240, 12'o1234, 0);   // R4 clear then invert -> 7777
    step(1, 8'o201, 12'o4444, 1);   // R4 clear then increment -> 1
    step(1, 8'o001, 12'o7777, 0);   // R3 carry flips link
    step(1, 8'o001, 12'o7777, 1);   // R3 carry flips link back
    step(1, 8'o041, 12'o0005, 0);   // R4 two's complement negate
    step(1, 8'o010, 12'o0001, 1);   // R5 right through link
    step(1, 8'o004, 12'o4000, 0);   // R5 left through link
    step(1, 8'o014, 12'o0001, 0);   // R5 both -> right wins
    step(1, 8'o012, 12'o0003, 1);   // R6 double right
    step(1, 8'o006, 12'o6000, 0);   // R6 double left
    step(1, 8'o002, 12'o1234, 1);   // R7 half swap
    step(0, 8'o200, 12'o7777, 1);   // R11 hold
    step(0, 8'o001, 12'o0000, 0);   // R11 hold
    step(1, 8'o011, 12'o7777, 0);   // R4 increment before rotate

    // every field against several accumulator patterns
    for (int u = 0; u < 256; u++) begin
      for (int k = 0; k < 6; k++) begin
        step(1, u, accs[k], (u + k) & 1);
      end
      if ((u % 16) == 15) step(0, u, 0, 0);
    end

    // random traffic with gaps
    for (int i = 0; i < 600; i++) begin
      step((($urandom % 5) != 0), $urandom % 256, $urandom % 4096, $urandom % 2);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule